// File: doc/BRIEF.md
# Boot Region Bus Width Adapter

This block sits between a requester that reads whole 32-bit words and an external memory port that may be 8, 16 or 32 bits wide. The width of the port comes from a region configuration code. The adapter turns one word read into a burst of narrower transfers and steps the address by the port width on each transfer. It packs the returned pieces little-endian into one word and reports completion to the requester with a single-cycle response.

A request can also be marked as a byte access. Such a request always makes exactly one byte transfer at the exact address given, whatever the configured width. This lets configuration bytes be read before the region width is known. Wait states reduce to a per-transfer ready handshake: the memory side holds `mem_ready` low until it can return data for the transfer it is shown.

Top module: `boot_width_adapter`

## Requirements
- R1: After reset, `mem_valid` and `rsp_valid` are low and `req_ready` is high.
- R2: When `region_width` is 2'b00 (8-bit), a word read makes four transfers with `mem_size` 2'b00 (byte), at the aligned base address plus 0, 1, 2 and 3, in that order.
- R3: When `region_width` is 2'b01 (16-bit), a word read makes two transfers with `mem_size` 2'b01 (half-word), at the aligned base and then the base plus 2.
- R4: When `region_width` is 2'b10 or 2'b11 (32-bit), a word read makes one transfer with `mem_size` 2'b10 (word) at the aligned base.
- R5: A request with `req_byte` high makes exactly one transfer with `mem_size` 2'b00 at the unmodified `req_addr`, for every `region_width` code. Its response is that byte in bits [7:0], with bits [31:8] zero.
- R6: For word reads, the two low bits of `req_addr` are ignored, and the burst starts at the word-aligned address.
- R7: Each transfer returns its data right-justified in `mem_rdata`, and only the low 8 bits (byte) or 16 bits (half) are used. Transfer k of a burst is placed at bits [k*8 +: 8] or [k*16 +: 16] of `rsp_data`.
- R8: `mem_first` is high only on the first transfer of a burst, and `mem_last` only on the final one. Both are high on a single-transfer access.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_size`, `mem_first` and `mem_last` hold their values.
- R10: `rsp_valid` goes high for exactly one cycle, in the cycle after the final transfer is accepted. `rsp_data` is valid in that cycle.
- R11: `req_ready` is low from the cycle after a request is accepted until the response cycle. `region_width` is sampled only when a request is accepted, so changing it during a burst has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| region_width | input | 2 | Port width code: 00 = 8-bit, 01 = 16-bit, 10 or 11 = 32-bit |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Adapter idle; a request is accepted when both are high |
| req_addr | input | ADDR_W | Byte address of the request |
| req_byte | input | 1 | Single-byte access, independent of width |
| mem_valid | output | 1 | Transfer presented to memory |
| mem_addr | output | ADDR_W | Transfer address |
| mem_size | output | 2 | Transfer size: 00 byte, 01 half, 10 word |
| mem_first | output | 1 | First transfer of a burst |
| mem_last | output | 1 | Final transfer of a burst |
| mem_ready | input | 1 | Memory accepts the transfer and drives its data |
| mem_rdata | input | 32 | Read data, right-justified |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 32 | Assembled word or zero-extended byte |

## Verification
The assertions assume that the memory raises `mem_ready` only while `mem_valid` is high. They also assume that the requester drives `req_valid` for a single cycle at a time, when `req_ready` is high. The bench keeps within these rules. Its memory model answers only the transfer it sees on the port, after 0 to 2 wait cycles, and it drops `req_valid` right after acceptance. The bench sweeps every width code, both access kinds, every low address offset and every wait count. It also changes `region_width` partway through each burst.

// File: rtl/bwa_pkg.sv
package bwa_pkg;

    localparam int WORD_W     = 32;
    localparam int WORD_BYTES = WORD_W / 8;

    typedef enum logic [1:0] {
        PW_8   = 2'b00,
        PW_16  = 2'b01,
        PW_32  = 2'b10,
        PW_32X = 2'b11
    } port_width_e;

    typedef enum logic [1:0] {
        XS_BYTE = 2'b00,
        XS_HALF = 2'b01,
        XS_WORD = 2'b10
    } xfer_size_e;

    typedef struct packed {
        xfer_size_e  size;
        logic [1:0]  last_idx;
    } burst_plan_t;

    function automatic burst_plan_t plan_burst(input logic [1:0] code, input logic byte_q);
        burst_plan_t p;
        if (byte_q) begin
            p.size     = XS_BYTE;
            p.last_idx = 2'd0;
        end else begin
            case (port_width_e'(code))
                PW_8:    begin p.size = XS_BYTE; p.last_idx = 2'd3; end
                PW_16:   begin p.size = XS_HALF; p.last_idx = 2'd1; end
                default: begin p.size = XS_WORD; p.last_idx = 2'd0; end
            endcase
        end
        return p;
    endfunction

endpackage

// File: rtl/bwa_planner.sv
module bwa_planner
    import bwa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        width_code,
    input  logic              byte_q,
    input  logic [ADDR_W-1:0] addr_in,
    output burst_plan_t       plan,
    output logic [ADDR_W-1:0] start_addr
);
    localparam int ALIGN_BITS = $clog2(WORD_BYTES);

    always_comb begin
        plan = plan_burst(width_code, byte_q);
        if (byte_q)
            start_addr = addr_in;
        else
            start_addr = {addr_in[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
    end
endmodule

// File: rtl/bwa_sequencer.sv
module bwa_sequencer
    import bwa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  burst_plan_t       plan_in,
    input  logic [ADDR_W-1:0] base_in,
    input  logic              mem_ready,
    output logic              busy,
    output logic [1:0]        beat_idx,
    output xfer_size_e        cur_size,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_first,
    output logic              mem_last,
    output logic              beat_done,
    output logic              burst_done
);
    burst_plan_t       plan_q;
    logic [ADDR_W-1:0] base_q;
    logic              byte_q_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            beat_idx <= 2'd0;
            plan_q   <= '{size: XS_BYTE, last_idx: 2'd0};
            base_q   <= '0;
        end else if (start) begin
            busy     <= 1'b1;
            beat_idx <= 2'd0;
            plan_q   <= plan_in;
            base_q   <= base_in;
        end else if (busy && mem_ready) begin
            if (beat_idx == plan_q.last_idx)
                busy <= 1'b0;
            else
                beat_idx <= beat_idx + 2'd1;
        end
    end

    always_comb begin
        cur_size    = plan_q.size;
        mem_addr    = base_q + ({{(ADDR_W-2){1'b0}}, beat_idx} << plan_q.size);
        mem_first   = busy && (beat_idx == 2'd0);
        mem_last    = busy && (beat_idx == plan_q.last_idx);
        beat_done   = busy && mem_ready;
        burst_done  = beat_done && mem_last;
        byte_q_seen = (plan_q.size == XS_BYTE) && (plan_q.last_idx == 2'd0);
    end

    // R9
    hold_while_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !mem_ready) |=> (busy && $stable(mem_addr) && $stable(cur_size)
                                  && $stable(mem_first) && $stable(mem_last)));

    // R6
    aligned_start_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_first && !byte_q_seen) |-> (mem_addr[1:0] == 2'b00));

    // R8
    word_single_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_first && cur_size == XS_WORD) |-> mem_last);

    // R11
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !burst_done) |=> busy);
endmodule

// File: rtl/bwa_packer.sv
module bwa_packer
    import bwa_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              beat_done,
    input  logic              burst_done,
    input  logic [1:0]        beat_idx,
    input  xfer_size_e        cur_size,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data
);
    logic [WORD_W-1:0] acc_q;
    logic [WORD_W-1:0] acc_nx;

    always_comb begin
        acc_nx = acc_q;
        case (cur_size)
            XS_BYTE: acc_nx[beat_idx*8 +: 8]       = mem_rdata[7:0];
            XS_HALF: acc_nx[beat_idx[0]*16 +: 16]  = mem_rdata[15:0];
            default: acc_nx                        = mem_rdata;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= burst_done;
            if (start)
                acc_q <= '0;
            else if (beat_done)
                acc_q <= acc_nx;
            if (burst_done)
                rsp_data <= acc_nx;
        end
    end

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/boot_width_adapter.sv
module boot_width_adapter
    import bwa_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        region_width,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_byte,
    output logic              mem_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic              mem_first,
    output logic              mem_last,
    input  logic              mem_ready,
    input  logic [31:0]       mem_rdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data
);
    burst_plan_t       plan;
    logic [ADDR_W-1:0] start_addr;
    logic              busy;
    logic              start;
    logic [1:0]        beat_idx;
    xfer_size_e        cur_size;
    logic              beat_done;
    logic              burst_done;

    assign req_ready = !busy;
    assign start     = req_valid && !busy;
    assign mem_valid = busy;
    assign mem_size  = cur_size;

    bwa_planner #(.ADDR_W(ADDR_W)) u_planner (
        .width_code (region_width),
        .byte_q     (req_byte),
        .addr_in    (req_addr),
        .plan       (plan),
        .start_addr (start_addr)
    );

    bwa_sequencer #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .plan_in    (plan),
        .base_in    (start_addr),
        .mem_ready  (mem_ready),
        .busy       (busy),
        .beat_idx   (beat_idx),
        .cur_size   (cur_size),
        .mem_addr   (mem_addr),
        .mem_first  (mem_first),
        .mem_last   (mem_last),
        .beat_done  (beat_done),
        .burst_done (burst_done)
    );

    bwa_packer u_pack (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .beat_done  (beat_done),
        .burst_done (burst_done),
        .beat_idx   (beat_idx),
        .cur_size   (cur_size),
        .mem_rdata  (mem_rdata),
        .rsp_valid  (rsp_valid),
        .rsp_data   (rsp_data)
    );

    // R10
    rsp_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_ready && mem_last) |=> (rsp_valid && req_ready));

    // R10
    no_stray_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_valid && mem_ready && mem_last) |=> !rsp_valid);

    // R8
    flags_need_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_first || mem_last) |-> mem_valid);

    // R11
    accept_goes_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (mem_valid && mem_first && !req_ready));
endmodule

// File: tb/test_boot_width_adapter.sv
module test_boot_width_adapter;
    localparam int ADDR_W = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [1:0]        region_width = 2'b00;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              req_byte = 1'b0;
    logic              mem_valid;
    logic [ADDR_W-1:0] mem_addr;
    logic [1:0]        mem_size;
    logic              mem_first;
    logic              mem_last;
    logic              mem_ready = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_data;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    boot_width_adapter #(.ADDR_W(ADDR_W)) i_boot_width_adapter (
        .clk(clk), .rst(rst), .region_width(region_width),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_byte(req_byte),
        .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_first(mem_first), .mem_last(mem_last), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        return a[7:0] * 8'd37 + a[15:8] + 8'h1B;
    endfunction

    function automatic logic [31:0] beat_data(input logic [31:0] a, input logic [1:0] sz);
        case (sz)
            2'b00:   return {24'hEEEEEE, mem_byte(a)};
            2'b01:   return {16'hEEEE, mem_byte(a + 1), mem_byte(a)};
            default: return {mem_byte(a + 3), mem_byte(a + 2), mem_byte(a + 1), mem_byte(a)};
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Enters and leaves at a negative edge.
    task automatic run_req(input logic [31:0] addr, input logic [1:0] wcode,
                           input bit byte_q, input int waits);
        int          nbeats;
        logic [1:0]  sz;
        logic [31:0] base;
        logic [31:0] exp_word;
        string       rtag;
        if (byte_q)            begin nbeats = 1; sz = 2'b00; rtag = "R5"; end
        else if (wcode == 2'b00) begin nbeats = 4; sz = 2'b00; rtag = "R2"; end
        else if (wcode == 2'b01) begin nbeats = 2; sz = 2'b01; rtag = "R3"; end
        else                   begin nbeats = 1; sz = 2'b10; rtag = "R4"; end
        base = byte_q ? addr : {addr[31:2], 2'b00};
        exp_word = byte_q ? {24'h0, mem_byte(addr)}
                          : {mem_byte(base + 3), mem_byte(base + 2), mem_byte(base + 1), mem_byte(base)};

        chk(req_ready == 1'b1, "R11 idle ready", req_ready, 1);
        region_width = wcode;
        req_addr  = addr;
        req_byte  = byte_q;
        req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid    = 1'b0;
        region_width = wcode + 2'd1;   // R11: change after acceptance
        for (int k = 0; k < nbeats; k++) begin
            logic [31:0] ea;
            ea = base + (k << sz);
            for (int w = 0; w <= waits; w++) begin
                chk(mem_valid == 1'b1, {rtag, " valid"}, mem_valid, 1);
                chk(mem_addr == ea, {rtag, " addr"}, mem_addr, ea);
                chk(mem_size == sz, {rtag, " size"}, mem_size, sz);
                chk(mem_first == (k == 0), "R8 first", mem_first, (k == 0));
                chk(mem_last == (k == nbeats - 1), "R8 last", mem_last, (k == nbeats - 1));
                chk(req_ready == 1'b0, "R11 busy", req_ready, 0);
                if (w > 0) chk(mem_addr == ea, "R9 hold", mem_addr, ea);
                if (w == waits) begin
                    mem_ready = 1'b1;
                    mem_rdata = beat_data(ea, sz);
                end
                @(posedge clk);
                @(negedge clk);
                mem_ready = 1'b0;
                mem_rdata = 32'hDEAD_BEEF;
            end
        end
        chk(rsp_valid == 1'b1, "R10 rsp high", rsp_valid, 1);
        chk(rsp_data == exp_word, byte_q ? "R5 data" : "R7 data", rsp_data, exp_word);
        if (!byte_q && addr[1:0] != 2'b00)
            chk(rsp_data == exp_word, "R6 unaligned word", rsp_data, exp_word);
        chk(mem_valid == 1'b0, "R10 idle after", mem_valid, 0);
        @(posedge clk);
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10 single cycle", rsp_valid, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(mem_valid == 1'b0, "R1 mem_valid", mem_valid, 0);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", rsp_valid, 0);
        chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
        for (int b = 0; b < 2; b++)
            for (int wc = 0; wc < 4; wc++)
                for (int bq = 0; bq < 2; bq++)
                    for (int off = 0; off < 4; off++)
                        for (int ws = 0; ws < 3; ws++) begin
                            logic [31:0] a;
                            a = (b == 0 ? 32'hFEFF_FF30 : 32'h0000_1A40) + off + 16 * ws;
                            run_req(a, wc[1:0], bq[0], ws);
                        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule